// File: doc/BRIEF.md
# Wake-Up Timer Counter with Keyed Coherent Snapshot

This block is a free-running wake-up timer. A 47-bit count moves forward on each cycle where the prescaled tick enable is high. The upper 32 bits are the integer part and the lower 15 bits are the fractional part. On every tick the count gains one integer unit (2^15) plus a signed 16-bit trim value, and it wraps modulo 2^47. Trimming lets software stretch or shrink the time base without touching the tick source.

Software reaches the block through a simple register port: a one-cycle write strobe, and a read address with a combinational read-data return. To take a snapshot, software writes a fixed 16-bit key to a gateway address. All three snapshot words then load at the same edge from one consistent count value, so software can read them at leisure without tearing. Three sticky status bits record separate events: a tick, a change of the integer part, and a wrap of the integer part. Software clears them by writing 1. Each status bit has an enable in a control register, and the interrupt output is a registered OR of the enabled status bits.

Top module: `wut_keyed_snap`

## Requirements
- R1: While tick_i is high at an edge, the count becomes (count + 32768 + sign-extended trim_i) mod 2^47. Without a tick the count holds. After reset the count equals parameter CNT_INIT.
- R2: A write of 16'h7627 to address 2 loads all three snapshots at that edge from the count as it stood before that edge. Address 3 reads count bits [46:31], address 4 reads bits [30:15], and address 5 reads bits [14:0] zero-extended to 16 bits.
- R3: A write to address 2 with any other value leaves all snapshot words unchanged. Address 2 reads as zero.
- R4: After reset all snapshot words read 0x0000, whatever CNT_INIT is.
- R5: Status bit 1 (read at address 1) sets at every edge where tick_i is high.
- R6: Status bit 0 sets at an edge where a tick changes count bits [46:15]. A tick that leaves them unchanged (for example trim_i = -32768) does not set it.
- R7: Status bit 3 sets at an edge where a tick carries the count past 2^47-1 to a lower value.
- R8: A write to address 1 clears each status bit whose data bit is 1. Data bits that are 0 have no effect. Bit 2 always reads 0. If a set event and a clear hit the same bit at the same edge, the bit ends up set. All status bits reset to 0.
- R9: A write to address 0 stores enables for bits 3, 1 and 0. Address 0 reads them back in the same positions, with all other bits zero. Addresses 6 and 7 read zero.
- R10: irq_o is high exactly one edge after any status bit is high together with its enable bit, and it is low otherwise. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Prescaled tick enable that advances the count |
| trim_i | input | 16 | Signed trim added to the count on each tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 16 | Combinational read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with CNT_INIT = 0x7FFF_FFFD_0000, which puts the integer part six ticks below its wrap point. This lets rollover, including a wrap with a fractional remainder, happen within a few dozen cycles instead of 2^32 ticks. Trims of -32768 and +32767 cover a tick that leaves the integer part alone and a tick that moves the fractional part while adding one integer unit. A long mixed run then compares every register and the interrupt against a behavioural model on every clock.

// File: rtl/wut_pkg.sv
`timescale 1ns/1ps
package wut_pkg;
  localparam int CNT_W  = 47;
  localparam int FRAC_W = 15;
  localparam int WORD_W = 16;
  localparam int TRIM_W = 16;
  localparam int ADDR_W = 3;
  localparam int STAT_W = 4;
  localparam int INT_W  = CNT_W - FRAC_W;

  typedef logic [CNT_W-1:0] cnt_t;

  localparam int ST_CHG  = 0;
  localparam int ST_PS   = 1;
  localparam int ST_ROLL = 3;
  localparam logic [STAT_W-1:0] ST_MASK = STAT_W'(4'b1011);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_GW   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_SHI  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_SLO  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SFR  = ADDR_W'(5);

  localparam logic [WORD_W-1:0] SNAP_KEY = WORD_W'(16'h7627);

  // count plus one integer unit plus signed trim; the top bit is the wrap carry
  function automatic logic [CNT_W:0] advance(cnt_t c, logic [TRIM_W-1:0] t);
    logic [CNT_W:0] unit;
    logic [CNT_W:0] ext;
    unit = (CNT_W+1)'(1) << FRAC_W;
    ext  = {{(CNT_W+1-TRIM_W){t[TRIM_W-1]}}, t};
    return {1'b0, c} + unit + ext;
  endfunction

  function automatic logic [INT_W-1:0] int_of(cnt_t c);
    return c[CNT_W-1:FRAC_W];
  endfunction
endpackage

// File: rtl/wut_counter.sv
`timescale 1ns/1ps
module wut_counter
  import wut_pkg::*;
#(
  parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [TRIM_W-1:0] trim_i,
  output cnt_t              cnt_o,
  output logic              chg_o,
  output logic              roll_o
);
  cnt_t           cnt_q;
  logic [CNT_W:0] sum;

  assign sum    = advance(cnt_q, trim_i);
  assign chg_o  = tick_i && (int_of(sum[CNT_W-1:0]) != int_of(cnt_q));
  assign roll_o = tick_i && sum[CNT_W];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_INIT;
    else if (tick_i) cnt_q <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/wut_status.sv
`timescale 1ns/1ps
module wut_status
  import wut_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_i,
  input  logic              clr_wr_i,
  input  logic [STAT_W-1:0] clr_data_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] set_m;
  logic [STAT_W-1:0] clr_m;

  assign set_m = set_i & ST_MASK;
  assign clr_m = clr_wr_i ? clr_data_i : '0;

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (ST_MASK[b]) begin : g_live
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_o[b] <= 1'b0;
        else        stat_o[b] <= set_m[b] | (stat_o[b] & ~clr_m[b]);
      end
    end else begin : g_rsv
      assign stat_o[b] = set_m[b] & clr_m[b];
    end
  end
endmodule

// File: rtl/wut_snap.sv
`timescale 1ns/1ps
module wut_snap
  import wut_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gw_wr_i,
  input  logic [WORD_W-1:0] gw_data_i,
  input  cnt_t              cnt_i,
  output cnt_t              snap_o,
  output logic              take_o
);
  assign take_o = gw_wr_i && (gw_data_i == SNAP_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap_o <= '0;
    else if (take_o) snap_o <= cnt_i;
  end
endmodule

// File: rtl/wut_keyed_snap.sv
`timescale 1ns/1ps
module wut_keyed_snap
  import wut_pkg::*;
#(
  parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              irq_o
);
  cnt_t              cnt_w;
  cnt_t              snap_w;
  logic              chg_evt;
  logic              roll_evt;
  logic              take_evt;
  logic [STAT_W-1:0] set_w;
  logic [STAT_W-1:0] stat_w;
  logic [STAT_W-1:0] en_q;
  logic              irq_q;

  wut_counter #(.CNT_INIT(CNT_INIT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .trim_i(trim_i),
    .cnt_o(cnt_w), .chg_o(chg_evt), .roll_o(roll_evt)
  );

  always_comb begin
    set_w          = '0;
    set_w[ST_CHG]  = chg_evt;
    set_w[ST_PS]   = tick_i;
    set_w[ST_ROLL] = roll_evt;
  end

  wut_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(set_w),
    .clr_wr_i(wr_en_i && (wr_addr_i == A_STAT)),
    .clr_data_i(wr_data_i[STAT_W-1:0]), .stat_o(stat_w)
  );

  wut_snap u_snap (
    .clk(clk), .rst_n(rst_n), .gw_wr_i(wr_en_i && (wr_addr_i == A_GW)),
    .gw_data_i(wr_data_i), .cnt_i(cnt_w), .snap_o(snap_w), .take_o(take_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_en_i && (wr_addr_i == A_CTRL)) en_q <= wr_data_i[STAT_W-1:0] & ST_MASK;
      irq_q <= |(stat_w & en_q);
    end
  end
  assign irq_o = irq_q;

  always_comb begin
    unique case (rd_addr_i)
      A_CTRL:  rd_data_o = {{(WORD_W-STAT_W){1'b0}}, en_q};
      A_STAT:  rd_data_o = {{(WORD_W-STAT_W){1'b0}}, stat_w};
      A_SHI:   rd_data_o = snap_w[CNT_W-1 -: WORD_W];
      A_SLO:   rd_data_o = snap_w[CNT_W-WORD_W-1 -: WORD_W];
      A_SFR:   rd_data_o = {{(WORD_W-FRAC_W){1'b0}}, snap_w[FRAC_W-1:0]};
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/wut_keyed_snap_chk.sv
`timescale 1ns/1ps
module wut_keyed_snap_chk
  import wut_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [WORD_W-1:0] wr_data_i,
  input logic [STAT_W-1:0] stat_q,
  input logic [STAT_W-1:0] en_q,
  input logic              irq_o,
  input cnt_t              cnt_q,
  input cnt_t              snap_q,
  input logic              chg_evt,
  input logic              roll_evt
);
  logic key_wr;
  logic clr0;
  assign key_wr = wr_en_i && (wr_addr_i == A_GW) && (wr_data_i == SNAP_KEY);
  assign clr0   = wr_en_i && (wr_addr_i == A_STAT) && wr_data_i[ST_CHG];

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));
  // R3
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(snap_q));
  // R2
  snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> (snap_q == $past(cnt_q)));
  // R5
  ps_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> stat_q[ST_PS]);
  // R6
  chg_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_evt |=> stat_q[ST_CHG]);
  // R7
  roll_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll_evt |=> stat_q[ST_ROLL]);
  // R8
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q[ST_CHG] && !clr0) |=> stat_q[ST_CHG]);
  // R8
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q[2]);
  // R10
  irq_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & en_q)) |=> irq_o);
  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(stat_q & en_q)) |=> !irq_o);
endmodule

bind wut_keyed_snap wut_keyed_snap_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .stat_q(stat_w), .en_q(en_q),
  .irq_o(irq_o), .cnt_q(cnt_w), .snap_q(snap_w), .chg_evt(chg_evt),
  .roll_evt(roll_evt)
);

// File: tb/wut_keyed_snap_tb.sv
`timescale 1ns/1ps
module wut_keyed_snap_tb_top;
  localparam logic [46:0] INIT = 47'h7FFF_FFFD_0000;
  localparam longint MASK = (64'sd1 <<< 47) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] trim = '0;
  logic        we = 1'b0;
  logic [2:0]  wa = '0;
  logic [15:0] wd = '0;
  logic [2:0]  ra = '0;
  logic [15:0] rd;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  wut_keyed_snap #(.CNT_INIT(INIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .trim_i(trim), .wr_en_i(we),
    .wr_addr_i(wa), .wr_data_i(wd), .rd_addr_i(ra), .rd_data_o(rd), .irq_o(irq)
  );

  always #4 clk = ~clk;

  // behavioural reference
  longint m_cnt, m_snap;
  int     m_stat, m_en;
  bit     m_irq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = longint'(INIT); m_snap = 0; m_stat = 0; m_en = 0; m_irq = 0;
    end else begin
      longint nxt;
      int     set, clr;
      bit     irq_n;
      irq_n = (m_stat & m_en) != 0;
      set = 0;
      nxt = m_cnt;
      if (tick) begin
        longint s;
        s = m_cnt + 32768 + longint'($signed(trim));
        nxt = s & MASK;
        set |= 2;
        if ((nxt >> 15) != (m_cnt >> 15)) set |= 1;
        if (s > MASK) set |= 8;
      end
      if (we && wa == 3'd2 && wd == 16'h7627) m_snap = m_cnt;
      clr = (we && wa == 3'd1) ? (int'(wd) & 11) : 0;
      m_stat = (m_stat & ~clr) | set;
      if (we && wa == 3'd0) m_en = int'(wd) & 11;
      m_cnt = nxt;
      m_irq = irq_n;
    end
  end

  function automatic int model_rd(logic [2:0] a);
    case (a)
      3'd0: return m_en;
      3'd1: return m_stat;
      3'd3: return int'((m_snap >> 31) & 16'hFFFF);
      3'd4: return int'((m_snap >> 15) & 16'hFFFF);
      3'd5: return int'(m_snap & 16'h7FFF);
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] a);
    case (a)
      3'd0, 3'd6, 3'd7: return "R9";
      3'd1: return "R8";
      3'd2: return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic check(int got, int exp, string tag);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // one clock: drive, let the edge pass, compare to the model
  task automatic cyc(bit t, int tr, bit w, int a, int d, int r);
    tick = t; trim = 16'(tr); we = w; wa = 3'(a); wd = 16'(d); ra = 3'(r);
    @(posedge clk);
    @(negedge clk);
    check(int'(rd), model_rd(ra), tag_of(ra));
    check(int'(irq), int'(m_irq), "R10");
    tick = 0; we = 0;
  endtask

  task automatic rdchk(int a, int exp, string tag);
    cyc(0, 0, 0, 0, 0, a);
    check(int'(rd), exp, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4 R8 R9 reset values
    for (int a = 0; a < 8; a++) rdchk(a, 0, a >= 3 && a <= 5 ? "R4" : "R9");
    // R2 capture from the initial count
    cyc(0, 0, 1, 2, 16'h7627, 3);
    rdchk(3, 16'hFFFF, "R2");
    rdchk(4, 16'hFFFA, "R2");
    rdchk(5, 0, "R2");
    // R5 R6 one plain tick
    cyc(1, 0, 0, 0, 0, 1);
    rdchk(1, 3, "R5");
    // R3 wrong key ignored
    cyc(0, 0, 1, 2, 16'h7626, 4);
    rdchk(4, 16'hFFFA, "R3");
    rdchk(2, 0, "R3");
    // R8 write-one-to-clear
    cyc(0, 0, 1, 1, 1, 1);
    rdchk(1, 2, "R8");
    cyc(0, 0, 1, 1, 0, 1);
    rdchk(1, 2, "R8");
    cyc(0, 0, 1, 1, 4, 1);
    rdchk(1, 2, "R8");
    cyc(0, 0, 1, 1, 2, 1);
    rdchk(1, 0, "R8");
    // R6 tick that leaves the integer part alone
    cyc(1, -32768, 0, 0, 0, 1);
    rdchk(1, 2, "R6");
    cyc(0, 0, 1, 1, 15, 1);
    // R1 positive trim
    cyc(1, 32767, 0, 0, 0, 1);
    cyc(0, 0, 1, 2, 16'h7627, 4);
    rdchk(4, 16'hFFFC, "R1");
    rdchk(5, 16'h7FFF, "R1");
    cyc(0, 0, 1, 1, 15, 1);
    // R7 approach and cross the wrap
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 0, 1);
    rdchk(1, 3, "R7");
    cyc(1, 0, 0, 0, 0, 1);
    rdchk(1, 11, "R7");
    cyc(0, 0, 1, 2, 16'h7627, 3);
    rdchk(3, 0, "R7");
    rdchk(4, 0, "R7");
    rdchk(5, 16'h7FFF, "R7");
    // R8 set beats clear at the same edge
    cyc(1, 0, 1, 1, 15, 1);
    rdchk(1, 3, "R8");
    // R9 R10 enables and registered interrupt
    cyc(0, 0, 1, 0, 16'hFFFF, 0);
    rdchk(0, 11, "R9");
    check(int'(irq), 1, "R10");
    cyc(0, 0, 1, 1, 15, 1);
    check(int'(irq), 1, "R10");
    cyc(0, 0, 0, 0, 0, 1);
    check(int'(irq), 0, "R10");
    cyc(0, 0, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 0, 1);
    check(int'(irq), 0, "R10");
    // mixed run against the model
    cyc(0, 0, 1, 0, 2, 0);
    for (int i = 0; i < 400; i++) begin
      int tr;
      tr = ((i * 7919) % 65536) - 32768;
      cyc((i % 3) != 0, tr, (i % 5) == 0, (i % 15 == 0) ? 1 : 2,
          (i % 10 == 0) ? 16'h7627 : (i * 13), i % 8);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule